// File: doc/BRIEF.md
# Self-Timed Page Array Operation Scheduler

This block sits behind a serial command front end and runs the long, self-timed operations of a page-organised non-volatile array. A command arrives as a one-cycle start pulse, an 8-bit opcode and a page number. The scheduler decodes the command into a short list of phases: copy a page into a buffer, compare a page with a buffer, fill a page or a block with ones, write a buffer into a page, or merge a buffer into a page with a bitwise AND. It then runs those phases back to back under one busy window. Each phase lasts a fixed number of clock cycles, set by a parameter.

The block holds a small behavioural array and two page buffers. A host port gives byte access to the buffers while an operation runs. Only the buffer that the running operation uses is locked; the other buffer stays fully usable. The block drives a busy flag, an active-high ready output and a sticky compare-mismatch flag. A write-protect input guards the lowest pages. An asynchronous active-low reset abandons any operation in flight.

Top module: `array_op_sched`

## Requirements
- R1: A start pulse that carries a recognised, unprotected opcode while the block is idle raises `busy` and lowers `ready` at the next clock edge. `ready` is always the inverse of `busy`.
- R2: The busy window has a fixed length for each opcode. Copying a page to buffer 0 or 1 (0x53/0x55) takes T_XFER cycles, and so does comparing (0x60/0x61). Programming with erase (0x83/0x86) and the combined page program (0x82/0x85) take T_ERASE+T_PROG. Programming without erase (0x88/0x89) takes T_PROG. Page erase (0x81) takes T_ERASE. Block erase (0x50) takes T_BERASE. Auto rewrite (0x58/0x59) takes T_XFER+T_ERASE+T_PROG. `busy` falls on the edge after the last cycle.
- R3: A start pulse that arrives while `busy` is high is discarded. It does not change the running window or any buffer.
- R4: A compare sets `cmp_miss` to 0 when every byte of the page equals the selected buffer, and to 1 otherwise. The flag keeps its value through all other operations until the next compare ends.
- R5: Programming with erase, including the combined form, leaves the page equal to the selected buffer, whatever the page held before.
- R6: Programming without erase leaves each page byte equal to the old byte ANDed with the buffer byte.
- R7: Page erase sets every byte of the page to 0xFF. Block erase sets to 0xFF all PAGES_PER_BLOCK pages whose page number shares its upper bits with the given page. The low log2(PAGES_PER_BLOCK) page bits are ignored, and pages outside the block are untouched.
- R8: Auto rewrite leaves the selected buffer holding the page contents, and the page contents unchanged.
- R9: A page copy loads the selected buffer with the page bytes and does not modify the other buffer.
- R10: While `wp_n` is low, erase, program and auto-rewrite commands aimed at a page below PROT_PAGES are dropped. For block erase, the first page of the block is the one tested. A dropped command raises no busy and changes neither the array nor `cmp_miss`. Copy and compare are never blocked.
- R11: While an operation that uses buffer b runs, host writes to buffer b are dropped and host reads of buffer b return 0x00. The other buffer is read and written normally. A host read returns data one cycle after `host_re`.
- R12: While `rst_n` is low, `busy` is 0, `ready` is 1 and `cmp_miss` is 0, even in the middle of an operation. After release the block accepts commands again.
- R13: Opcodes outside the set in R2 are dropped without raising busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle pulse presenting a command |
| cmd_op | input | 8 | Command opcode |
| cmd_page | input | log2(NUM_PAGES) | Target page number |
| wp_n | input | 1 | Write protect, active low |
| host_we | input | 1 | Host buffer byte write strobe |
| host_re | input | 1 | Host buffer byte read strobe |
| host_sel | input | 1 | Host buffer select |
| host_addr | input | log2(PAGE_BYTES) | Host byte address in the buffer |
| host_wdata | input | DATA_W | Host write byte |
| host_rdata | output | DATA_W | Host read byte, registered |
| busy | output | 1 | Operation in progress |
| ready | output | 1 | Inverse of busy |
| cmp_miss | output | 1 | Result of the latest compare, 1 on mismatch |

## Verification
`busy` is due one edge after the start pulse. It then stays high for exactly the phase sum of the opcode. The bench samples one nanosecond after each rising edge, counts the samples in which `busy` is high, and compares that count with the R2 sum. Dropped commands must give a count of zero. A host read is due one edge after `host_re`, and `cmp_miss` is due by the time `busy` falls, so both are sampled only after their edge has passed. Array contents are checked through page-to-buffer copies followed by host reads, and every expected byte is computed from the pattern formulas in the bench.

// File: rtl/aos_pkg.sv
package aos_pkg;
   localparam int NBUF = 2;

   // command codes; buffer selection follows each pair
   localparam logic [7:0] OPC_COPY0    = 8'h53;
   localparam logic [7:0] OPC_COPY1    = 8'h55;
   localparam logic [7:0] OPC_CMP0     = 8'h60;
   localparam logic [7:0] OPC_CMP1     = 8'h61;
   localparam logic [7:0] OPC_ERPROG0  = 8'h83;
   localparam logic [7:0] OPC_ERPROG1  = 8'h86;
   localparam logic [7:0] OPC_FULLPG0  = 8'h82;
   localparam logic [7:0] OPC_FULLPG1  = 8'h85;
   localparam logic [7:0] OPC_MERGE0   = 8'h88;
   localparam logic [7:0] OPC_MERGE1   = 8'h89;
   localparam logic [7:0] OPC_PG_CLR   = 8'h81;
   localparam logic [7:0] OPC_BLK_CLR  = 8'h50;
   localparam logic [7:0] OPC_REFRESH0 = 8'h58;
   localparam logic [7:0] OPC_REFRESH1 = 8'h59;

   typedef enum logic [2:0] {
      PH_XFER, PH_CMP, PH_ERASE, PH_BERASE, PH_PROG, PH_PAND
   } phase_e;

   typedef enum logic [2:0] {
      ST_NONE, ST_COPY, ST_FILL, ST_PROG, ST_MASK
   } store_op_e;

   typedef struct packed {
      logic       ok;
      logic       lock;
      logic       bsel;
      logic [1:0] nph;
      phase_e     ph0;
      phase_e     ph1;
      phase_e     ph2;
   } plan_t;
endpackage

// File: rtl/aos_decode.sv
module aos_decode
   import aos_pkg::*;
#(
   parameter int NUM_PAGES       = 32,
   parameter int PAGES_PER_BLOCK = 8,
   parameter int PROT_PAGES      = 8,
   localparam int PA_W  = $clog2(NUM_PAGES),
   localparam int PPB_W = $clog2(PAGES_PER_BLOCK)
) (
   input  logic [7:0]      op_i,
   input  logic [PA_W-1:0] page_i,
   input  logic            wp_n,
   output plan_t           plan_o
);
   localparam logic [PA_W:0] PROT_LIM = (PA_W+1)'(PROT_PAGES);

   logic is_blk;
   logic prot_hit;
   logic guarded;

   assign is_blk = (op_i == OPC_BLK_CLR);

   generate
      if (PROT_PAGES == 0) begin : g_open
         assign prot_hit = 1'b0;
      end else begin : g_guard
         logic [PA_W-1:0] blk_base;
         logic [PA_W-1:0] test_pg;
         assign blk_base = {page_i[PA_W-1:PPB_W], {PPB_W{1'b0}}};
         assign test_pg  = is_blk ? blk_base : page_i;
         assign prot_hit = !wp_n && ({1'b0, test_pg} < PROT_LIM);
      end
   endgenerate

   always_comb begin
      plan_o  = '{ok: 1'b0, lock: 1'b0, bsel: 1'b0, nph: 2'd1,
                  ph0: PH_XFER, ph1: PH_XFER, ph2: PH_XFER};
      guarded = 1'b0;
      case (op_i)
         OPC_COPY0, OPC_COPY1: begin
            plan_o.ok   = 1'b1;
            plan_o.lock = 1'b1;
            plan_o.bsel = (op_i == OPC_COPY1);
         end
         OPC_CMP0, OPC_CMP1: begin
            plan_o.ok   = 1'b1;
            plan_o.lock = 1'b1;
            plan_o.bsel = (op_i == OPC_CMP1);
            plan_o.ph0  = PH_CMP;
         end
         OPC_ERPROG0, OPC_ERPROG1, OPC_FULLPG0, OPC_FULLPG1: begin
            plan_o.ok   = 1'b1;
            plan_o.lock = 1'b1;
            plan_o.bsel = (op_i == OPC_ERPROG1) || (op_i == OPC_FULLPG1);
            plan_o.nph  = 2'd2;
            plan_o.ph0  = PH_ERASE;
            plan_o.ph1  = PH_PROG;
            guarded     = 1'b1;
         end
         OPC_MERGE0, OPC_MERGE1: begin
            plan_o.ok   = 1'b1;
            plan_o.lock = 1'b1;
            plan_o.bsel = (op_i == OPC_MERGE1);
            plan_o.ph0  = PH_PAND;
            guarded     = 1'b1;
         end
         OPC_PG_CLR: begin
            plan_o.ok  = 1'b1;
            plan_o.ph0 = PH_ERASE;
            guarded    = 1'b1;
         end
         OPC_BLK_CLR: begin
            plan_o.ok  = 1'b1;
            plan_o.ph0 = PH_BERASE;
            guarded    = 1'b1;
         end
         OPC_REFRESH0, OPC_REFRESH1: begin
            plan_o.ok   = 1'b1;
            plan_o.lock = 1'b1;
            plan_o.bsel = (op_i == OPC_REFRESH1);
            plan_o.nph  = 2'd3;
            plan_o.ph0  = PH_XFER;
            plan_o.ph1  = PH_ERASE;
            plan_o.ph2  = PH_PROG;
            guarded     = 1'b1;
         end
         default: plan_o.ok = 1'b0;
      endcase
      if (guarded && prot_hit) plan_o.ok = 1'b0;
   end
endmodule

// File: rtl/aos_seq.sv
module aos_seq
   import aos_pkg::*;
#(
   parameter int NUM_PAGES       = 32,
   parameter int PAGE_BYTES      = 8,
   parameter int PAGES_PER_BLOCK = 8,
   parameter int DATA_W          = 8,
   parameter int T_XFER          = 12,
   parameter int T_ERASE         = 20,
   parameter int T_BERASE        = 70,
   parameter int T_PROG          = 16,
   localparam int PA_W      = $clog2(NUM_PAGES),
   localparam int BYTE_W    = $clog2(PAGE_BYTES),
   localparam int PPB_W     = $clog2(PAGES_PER_BLOCK),
   localparam int BLK_BYTES = PAGES_PER_BLOCK * PAGE_BYTES,
   localparam int T_MAX1    = (T_XFER > T_ERASE) ? T_XFER : T_ERASE,
   localparam int T_MAX2    = (T_BERASE > T_PROG) ? T_BERASE : T_PROG,
   localparam int T_MAX     = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2,
   localparam int CNT_W     = $clog2(T_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  plan_t             plan_i,
   input  logic [PA_W-1:0]   page_i,
   input  logic [DATA_W-1:0] arr_byte_i,
   input  logic [DATA_W-1:0] buf_byte_i,
   output logic              busy_o,
   output logic              cmp_o,
   output store_op_e         s_op_o,
   output logic [PA_W-1:0]   s_page_o,
   output logic [BYTE_W-1:0] s_byte_o,
   output logic              s_buf_o,
   output logic              lock_o,
   output logic              lock_buf_o
);
   logic             run_q;
   plan_t            pl_q;
   logic [PA_W-1:0]  pg_q;
   logic [1:0]       pidx_q;
   logic [CNT_W-1:0] cnt_q;
   logic             acc_q;
   logic             cmp_q;

   phase_e           cur;
   logic [CNT_W-1:0] dur_m1;
   logic             act;
   logic             last_tick;
   logic             last_phase;

   always_comb begin
      case (pidx_q)
         2'd0:    cur = pl_q.ph0;
         2'd1:    cur = pl_q.ph1;
         default: cur = pl_q.ph2;
      endcase
      case (cur)
         PH_XFER, PH_CMP: dur_m1 = CNT_W'(T_XFER - 1);
         PH_ERASE:        dur_m1 = CNT_W'(T_ERASE - 1);
         PH_BERASE:       dur_m1 = CNT_W'(T_BERASE - 1);
         default:         dur_m1 = CNT_W'(T_PROG - 1);
      endcase
      if (cur == PH_BERASE) act = run_q && (cnt_q < CNT_W'(BLK_BYTES));
      else                  act = run_q && (cnt_q < CNT_W'(PAGE_BYTES));
      last_tick  = run_q && (cnt_q == dur_m1);
      last_phase = (pidx_q == pl_q.nph - 2'd1);
   end

   // byte-serial access that each phase drives into the store
   always_comb begin
      s_op_o = ST_NONE;
      if (act) begin
         case (cur)
            PH_XFER:             s_op_o = ST_COPY;
            PH_ERASE, PH_BERASE: s_op_o = ST_FILL;
            PH_PROG:             s_op_o = ST_PROG;
            PH_PAND:             s_op_o = ST_MASK;
            default:             s_op_o = ST_NONE;
         endcase
      end
      if (cur == PH_BERASE) s_page_o = {pg_q[PA_W-1:PPB_W], cnt_q[BYTE_W +: PPB_W]};
      else                  s_page_o = pg_q;
   end

   assign s_byte_o   = cnt_q[BYTE_W-1:0];
   assign s_buf_o    = pl_q.bsel;
   assign busy_o     = run_q;
   assign cmp_o      = cmp_q;
   assign lock_o     = run_q && pl_q.lock;
   assign lock_buf_o = pl_q.bsel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         pl_q   <= '0;
         pg_q   <= '0;
         pidx_q <= '0;
         cnt_q  <= '0;
         acc_q  <= 1'b0;
         cmp_q  <= 1'b0;
      end else if (!run_q) begin
         if (start_i && plan_i.ok) begin
            run_q  <= 1'b1;
            pl_q   <= plan_i;
            pg_q   <= page_i;
            pidx_q <= '0;
            cnt_q  <= '0;
            acc_q  <= 1'b0;
         end
      end else begin
         if (cur == PH_CMP && act && (arr_byte_i != buf_byte_i)) acc_q <= 1'b1;
         if (last_tick) begin
            if (cur == PH_CMP) cmp_q <= acc_q;
            cnt_q <= '0;
            acc_q <= 1'b0;
            if (last_phase) run_q  <= 1'b0;
            else            pidx_q <= pidx_q + 2'd1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // R1: an accepted command shows busy one edge later
   p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && start_i && plan_i.ok) |=> run_q);

   // R2: the phase counter never passes the phase window
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q <= dur_m1));

   // R3: a running operation keeps its page and stays busy until its last tick
   p_hold_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !last_tick) |=> (run_q && $stable(pg_q)));

   // R4: the compare result moves only at the end of a compare phase
   p_cmp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(run_q && cur == PH_CMP && last_tick) |=> $stable(cmp_q));
endmodule

// File: rtl/aos_store.sv
module aos_store
   import aos_pkg::*;
#(
   parameter int NUM_PAGES  = 32,
   parameter int PAGE_BYTES = 8,
   parameter int DATA_W     = 8,
   localparam int PA_W   = $clog2(NUM_PAGES),
   localparam int BYTE_W = $clog2(PAGE_BYTES),
   localparam int ARR_N  = NUM_PAGES * PAGE_BYTES,
   localparam int ARR_W  = PA_W + BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  store_op_e         s_op_i,
   input  logic [PA_W-1:0]   s_page_i,
   input  logic [BYTE_W-1:0] s_byte_i,
   input  logic              s_buf_i,
   output logic [DATA_W-1:0] arr_byte_o,
   output logic [DATA_W-1:0] buf_byte_o,
   input  logic              h_we,
   input  logic              h_re,
   input  logic              h_sel,
   input  logic [BYTE_W-1:0] h_addr,
   input  logic [DATA_W-1:0] h_wdata,
   input  logic              h_lock,
   output logic [DATA_W-1:0] h_rdata
);
   logic [DATA_W-1:0] arr_q [ARR_N];
   logic [ARR_W-1:0]  arr_idx;
   logic [DATA_W-1:0] bseq  [NBUF];
   logic [DATA_W-1:0] bhost [NBUF];

   assign arr_idx    = {s_page_i, s_byte_i};
   assign arr_byte_o = arr_q[arr_idx];
   assign buf_byte_o = bseq[s_buf_i];

   always_ff @(posedge clk) begin
      case (s_op_i)
         ST_FILL: arr_q[arr_idx] <= '1;
         ST_PROG: arr_q[arr_idx] <= buf_byte_o;
         ST_MASK: arr_q[arr_idx] <= arr_q[arr_idx] & buf_byte_o;
         default: ;
      endcase
   end

   generate
      for (genvar b = 0; b < NBUF; b++) begin : g_buf
         logic [DATA_W-1:0] mem [PAGE_BYTES];
         logic seq_wr;
         logic host_wr;
         assign seq_wr  = (s_op_i == ST_COPY) && (s_buf_i == 1'(b));
         assign host_wr = h_we && !h_lock && (h_sel == 1'(b));
         always_ff @(posedge clk) begin
            if (seq_wr)       mem[s_byte_i] <= arr_byte_o;
            else if (host_wr) mem[h_addr]   <= h_wdata;
         end
         assign bseq[b]  = mem[s_byte_i];
         assign bhost[b] = mem[h_addr];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    h_rdata <= '0;
      else if (h_re) h_rdata <= h_lock ? '0 : bhost[h_sel];
   end

   // R11: a read of the locked buffer returns zero on the following cycle
   p_lock_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (h_re && h_lock) |=> (h_rdata == '0));
endmodule

// File: rtl/array_op_sched.sv
module array_op_sched
   import aos_pkg::*;
#(
   parameter int NUM_PAGES       = 32,
   parameter int PAGE_BYTES      = 8,
   parameter int PAGES_PER_BLOCK = 8,
   parameter int PROT_PAGES      = 8,
   parameter int DATA_W          = 8,
   parameter int T_XFER          = 12,
   parameter int T_ERASE         = 20,
   parameter int T_BERASE        = 70,
   parameter int T_PROG          = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cmd_start,
   input  logic [7:0]                    cmd_op,
   input  logic [$clog2(NUM_PAGES)-1:0]  cmd_page,
   input  logic                          wp_n,
   input  logic                          host_we,
   input  logic                          host_re,
   input  logic                          host_sel,
   input  logic [$clog2(PAGE_BYTES)-1:0] host_addr,
   input  logic [DATA_W-1:0]             host_wdata,
   output logic [DATA_W-1:0]             host_rdata,
   output logic                          busy,
   output logic                          ready,
   output logic                          cmp_miss
);
   localparam int PA_W      = $clog2(NUM_PAGES);
   localparam int BYTE_W    = $clog2(PAGE_BYTES);
   localparam int BLK_BYTES = PAGES_PER_BLOCK * PAGE_BYTES;

   generate
      if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_pb
         $error("PAGE_BYTES must be a power of two of at least 2");
      end
      if (NUM_PAGES < 4 || (NUM_PAGES & (NUM_PAGES - 1)) != 0) begin : g_bad_np
         $error("NUM_PAGES must be a power of two of at least 4");
      end
      if (PAGES_PER_BLOCK < 2 || PAGES_PER_BLOCK >= NUM_PAGES ||
          (PAGES_PER_BLOCK & (PAGES_PER_BLOCK - 1)) != 0) begin : g_bad_ppb
         $error("PAGES_PER_BLOCK must be a power of two between 2 and NUM_PAGES/2");
      end
      if (PROT_PAGES < 0 || PROT_PAGES > NUM_PAGES) begin : g_bad_prot
         $error("PROT_PAGES out of range");
      end
      if (T_XFER <= PAGE_BYTES || T_ERASE <= PAGE_BYTES || T_PROG <= PAGE_BYTES) begin : g_bad_t
         $error("page phase windows must exceed PAGE_BYTES cycles");
      end
      if (T_BERASE <= BLK_BYTES) begin : g_bad_tb
         $error("T_BERASE must exceed the bytes of one block");
      end
   endgenerate

   plan_t             plan;
   store_op_e         s_op;
   logic [PA_W-1:0]   s_page;
   logic [BYTE_W-1:0] s_byte;
   logic              s_buf;
   logic [DATA_W-1:0] arr_byte;
   logic [DATA_W-1:0] buf_byte;
   logic              lock;
   logic              lock_buf;
   logic              h_lock;

   aos_decode #(
      .NUM_PAGES(NUM_PAGES), .PAGES_PER_BLOCK(PAGES_PER_BLOCK), .PROT_PAGES(PROT_PAGES)
   ) u_decode (
      .op_i(cmd_op), .page_i(cmd_page), .wp_n(wp_n), .plan_o(plan)
   );

   aos_seq #(
      .NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES), .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
      .DATA_W(DATA_W), .T_XFER(T_XFER), .T_ERASE(T_ERASE), .T_BERASE(T_BERASE),
      .T_PROG(T_PROG)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(cmd_start), .plan_i(plan), .page_i(cmd_page),
      .arr_byte_i(arr_byte), .buf_byte_i(buf_byte), .busy_o(busy), .cmp_o(cmp_miss),
      .s_op_o(s_op), .s_page_o(s_page), .s_byte_o(s_byte), .s_buf_o(s_buf),
      .lock_o(lock), .lock_buf_o(lock_buf)
   );

   assign h_lock = lock && (lock_buf == host_sel);
   assign ready  = !busy;

   aos_store #(
      .NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .s_op_i(s_op), .s_page_i(s_page), .s_byte_i(s_byte),
      .s_buf_i(s_buf), .arr_byte_o(arr_byte), .buf_byte_o(buf_byte),
      .h_we(host_we), .h_re(host_re), .h_sel(host_sel), .h_addr(host_addr),
      .h_wdata(host_wdata), .h_lock(h_lock), .h_rdata(host_rdata)
   );
endmodule

// File: tb/array_op_sched_tb.sv
module array_op_sched_tb;
   localparam int NP = 32, PB = 8, PPB = 8, PROT = 8;
   localparam int TX = 12, TE = 20, TB = 70, TP = 16;

   // op, page, wp_n, expected busy cycles
   localparam logic [32:0] VEC [15] = '{
      {8'h53, 8'd28, 1'b1, 16'(TX)},
      {8'h55, 8'd29, 1'b1, 16'(TX)},
      {8'h60, 8'd28, 1'b1, 16'(TX)},
      {8'h83, 8'd28, 1'b1, 16'(TE + TP)},
      {8'h88, 8'd29, 1'b1, 16'(TP)},
      {8'h81, 8'd30, 1'b1, 16'(TE)},
      {8'h50, 8'd29, 1'b1, 16'(TB)},
      {8'h82, 8'd31, 1'b1, 16'(TE + TP)},
      {8'h59, 8'd30, 1'b1, 16'(TX + TE + TP)},
      {8'h81, 8'd2,  1'b0, 16'd0},
      {8'h50, 8'd5,  1'b0, 16'd0},
      {8'h57, 8'd28, 1'b1, 16'd0},
      {8'h53, 8'd2,  1'b0, 16'(TX)},
      {8'h86, 8'd9,  1'b0, 16'(TE + TP)},
      {8'h88, 8'd7,  1'b0, 16'd0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_start = 1'b0;
   logic [7:0] cmd_op = '0;
   logic [4:0] cmd_page = '0;
   logic       wp_n = 1'b1;
   logic       host_we = 1'b0, host_re = 1'b0, host_sel = 1'b0;
   logic [2:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       busy, ready, cmp_miss;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   logic [7:0] rb [PB];

   always #4 clk = ~clk;

   array_op_sched #(
      .NUM_PAGES(NP), .PAGE_BYTES(PB), .PAGES_PER_BLOCK(PPB), .PROT_PAGES(PROT),
      .DATA_W(8), .T_XFER(TX), .T_ERASE(TE), .T_BERASE(TB), .T_PROG(TP)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
      .cmd_page(cmd_page), .wp_n(wp_n), .host_we(host_we), .host_re(host_re),
      .host_sel(host_sel), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .busy(busy), .ready(ready), .cmp_miss(cmp_miss)
   );

   function automatic logic [7:0] pv(input int kind, input int i);
      case (kind)
         0:       return 8'(8'h3C + 17 * i);
         1:       return 8'(8'hF0 ^ (37 * i));
         default: return 8'h00;
      endcase
   endfunction

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic issue(input logic [7:0] op, input int pg, input logic wp);
      wp_n      = wp;
      cmd_op    = op;
      cmd_page  = 5'(pg);
      cmd_start = 1'b1;
      tick();
      cmd_start = 1'b0;
   endtask

   task automatic run_cmd(input logic [7:0] op, input int pg, input logic wp, output int cyc);
      int guard;
      issue(op, pg, wp);
      cyc   = busy ? 1 : 0;
      guard = 0;
      while (busy && guard < 1000) begin
         tick();
         guard++;
         if (busy) cyc++;
      end
      wp_n = 1'b1;
   endtask

   task automatic bwrite(input logic sel, input int a, input logic [7:0] d);
      host_sel = sel; host_addr = 3'(a); host_wdata = d; host_we = 1'b1;
      tick();
      host_we = 1'b0;
   endtask

   task automatic bread(input logic sel, input int a, output logic [7:0] d);
      host_sel = sel; host_addr = 3'(a); host_re = 1'b1;
      tick();
      host_re = 1'b0;
      d = host_rdata;
   endtask

   task automatic fillb(input logic sel, input int kind);
      for (int i = 0; i < PB; i++) bwrite(sel, i, pv(kind, i));
   endtask

   // copy a page into a buffer, then read the buffer out into rb
   task automatic pull(input int pg, input logic sel);
      int c;
      logic [7:0] d;
      run_cmd(sel ? 8'h55 : 8'h53, pg, 1'b1, c);
      for (int i = 0; i < PB; i++) begin
         bread(sel, i, d);
         rb[i] = d;
      end
   endtask

   task automatic chk_rb(input string tag, input int kind, input int mode);
      for (int i = 0; i < PB; i++) begin
         logic [7:0] e;
         case (mode)
            0:       e = 8'hFF;
            1:       e = pv(kind, i);
            default: e = pv(0, i) & pv(1, i);
         endcase
         chk(tag, int'(rb[i]), int'(e));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int c;
      logic [7:0] d;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R12 reset state
      chk("R12 busy after reset", int'(busy), 0);
      chk("R12 ready after reset", int'(ready), 1);
      chk("R12 cmp after reset", int'(cmp_miss), 0);

      // vector walk: busy timing per opcode, drops
      for (int k = 0; k < 15; k++) begin
         logic [7:0] op;
         int pg, exp;
         string tag;
         op  = VEC[k][32:25];
         pg  = int'(VEC[k][24:17]);
         exp = int'(VEC[k][15:0]);
         tag = (k == 9 || k == 10 || k == 14) ? "R10 dropped" : (k == 11 ? "R13 unknown op" : "R2 window");
         issue(op, pg, VEC[k][16]);
         chk("R1 ready after start", int'(ready), exp > 0 ? 0 : 1);
         c = busy ? 1 : 0;
         while (busy && c < 1000) begin
            tick();
            if (busy) c++;
         end
         wp_n = 1'b1;
         chk(tag, c, exp);
      end

      // R7 page erase, via copy (R9)
      run_cmd(8'h81, 20, 1'b1, c);
      pull(20, 1'b0);
      chk_rb("R7/R9 erased page copied", 0, 0);

      // R5 program with erase
      fillb(1'b1, 0);
      run_cmd(8'h86, 20, 1'b1, c);
      pull(20, 1'b0);
      chk_rb("R5 page equals buffer", 0, 1);
      bread(1'b1, 3, d);
      chk("R9 other buffer untouched", int'(d), int'(pv(0, 3)));

      // R4 compare
      run_cmd(8'h60, 20, 1'b1, c);
      chk("R4 match", int'(cmp_miss), 0);
      bwrite(1'b0, 5, ~pv(0, 5));
      run_cmd(8'h60, 20, 1'b1, c);
      chk("R4 mismatch", int'(cmp_miss), 1);
      run_cmd(8'h55, 20, 1'b1, c);
      chk("R4 retained", int'(cmp_miss), 1);
      run_cmd(8'h61, 20, 1'b1, c);
      chk("R4 match again", int'(cmp_miss), 0);

      // R6 program without erase
      fillb(1'b1, 1);
      run_cmd(8'h89, 20, 1'b1, c);
      pull(20, 1'b0);
      chk_rb("R6 AND merge", 0, 2);

      // R8 auto rewrite
      fillb(1'b1, 0);
      run_cmd(8'h86, 24, 1'b1, c);
      fillb(1'b0, 2);
      run_cmd(8'h58, 24, 1'b1, c);
      for (int i = 0; i < PB; i++) begin
         bread(1'b0, i, d);
         rb[i] = d;
      end
      chk_rb("R8 buffer holds page", 0, 1);
      pull(24, 1'b1);
      chk_rb("R8 page unchanged", 0, 1);

      // R7 block erase with nonzero low page bits
      run_cmd(8'h50, 21, 1'b1, c);
      pull(16, 1'b0);
      chk_rb("R7 block first page", 0, 0);
      pull(23, 1'b0);
      chk_rb("R7 block last page", 0, 0);
      pull(24, 1'b0);
      chk_rb("R7 next block untouched", 0, 1);

      // R10 protection keeps contents
      fillb(1'b1, 0);
      run_cmd(8'h86, 3, 1'b1, c);
      chk("R10 open when wp high", c, TE + TP);
      run_cmd(8'h81, 3, 1'b0, c);
      chk("R10 erase blocked", c, 0);
      fillb(1'b1, 1);
      run_cmd(8'h83 + 8'h03, 3, 1'b0, c);
      chk("R10 program blocked", c, 0);
      pull(3, 1'b0);
      chk_rb("R10 page unchanged", 0, 1);
      chk("R10 cmp unchanged", int'(cmp_miss), 0);

      // R11 buffer lock and R3 start while busy
      bwrite(1'b1, 1, 8'h5A);
      issue(8'h83, 26, 1'b1);
      c = busy ? 1 : 0;
      bwrite(1'b0, 0, 8'hAA);
      if (busy) c++;
      bread(1'b0, 0, d);
      if (busy) c++;
      chk("R11 locked read zero", int'(d), 0);
      bwrite(1'b1, 1, 8'h77);
      if (busy) c++;
      bread(1'b1, 1, d);
      if (busy) c++;
      chk("R11 other buffer usable", int'(d), 8'h77);
      issue(8'h55, 20, 1'b1);
      if (busy) c++;
      while (busy && c < 1000) begin
         tick();
         if (busy) c++;
      end
      chk("R3 window unchanged", c, TE + TP);
      bread(1'b1, 1, d);
      chk("R3 dropped copy left buffer", int'(d), 8'h77);
      bread(1'b0, 0, d);
      chk("R11 locked write dropped", int'(d), int'(pv(0, 0)));

      // R12 reset mid operation
      issue(8'h50, 29, 1'b1);
      repeat (4) tick();
      rst_n = 1'b0;
      #1;
      chk("R12 busy cleared", int'(busy), 0);
      chk("R12 ready set", int'(ready), 1);
      repeat (3) tick();
      chk("R12 held idle", int'(busy), 0);
      rst_n = 1'b1;
      tick();
      run_cmd(8'h53, 20, 1'b1, c);
      chk("R12 resumes", c, TX);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule